// File: doc/BRIEF.md
# Reloading Update-Event Timer

This block is an up-counting event timer for a processor subsystem. A register port lets software set a clock divider and a terminal count, then start the counter. Each time the count steps past the terminal value, the block produces an update event. That event restarts the counter at zero, raises a sticky status flag and, when enabled, drives the interrupt line. A single-shot setting stops the counter at its first update, so one programmed delay yields exactly one interrupt.

Both the divider and the terminal count have a pending copy and an active copy. The divider always waits for an update event before a new value takes effect. The terminal count does the same when buffering is selected, and otherwise takes effect on the write. Software can force an update at any time. The counter width is a parameter, 16 or 32 bits. Software can find the implemented width by writing all ones to the terminal count and reading it back.

Top module: `upd_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is low and the counter is 0. The register map is: control 0x00, interrupt enable 0x04, status 0x08, event 0x0C, divider 0x10, terminal count 0x14, counter (read-only) 0x18.
- R2: While control bit 0 (run) is 1, the counter steps once every D+1 clocks, where D is the active divider. With active terminal count T it counts 0..T. The step after T is an update event that returns it to 0, so updates come every (T+1)(D+1) clocks.
- R3: Every update event sets status bit 0. `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R4: Writing status with bit 0 equal to 0 clears the flag. Writing it with bit 0 equal to 1 leaves the flag unchanged.
- R5: When control bit 1 (single-shot) is set, a counter-driven update clears control bit 0, and the counter then stays at 0.
- R6: A divider write changes only the pending copy. The active divider takes the pending value at the next update event.
- R7: When control bit 2 (buffered reload) is 1, a terminal-count write reaches the active copy only at the next update event. When bit 2 is 0, the write is active at once.
- R8: Writing the event register with bit 0 equal to 1 forces an update event. The counter and divider phase go to 0, both pending copies load, and the status flag is set. Writing it with bit 0 equal to 0 has no effect.
- R9: With an active terminal count of 0, the counter stays at 0 and no counter-driven update occurs.
- R10: A terminal-count read returns the written value truncated to CNT_W bits. Writing 0xFFFFFFFF reads back 0x0000FFFF when CNT_W is 16.
- R11: While run is 0 and no update is forced, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Update interrupt, level |

## Verification
The assertions assume that at most one register is written per clock, since the port carries a single address. They also assume that a control write in the same cycle as a single-shot update has the final say over the run bit. The bench drives every write for exactly one cycle, changing inputs on the falling edge. It starts the counter only after a forced update has loaded the shadows and the flag has been cleared, so each measured period begins from a known phase of zero.

// File: rtl/upd_timer.sv
module upd_timer #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_PSC  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_ARR  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h18);

  logic             run, single, buffered, ien, flag;
  logic [PSC_W-1:0] psc_pre, psc_act, pcnt;
  logic [CNT_W-1:0] arr_pre, arr_act, cnt;

  wire wr_ctrl = wr_en && (wr_addr == A_CTRL);
  wire wr_ien  = wr_en && (wr_addr == A_IEN);
  wire wr_stat = wr_en && (wr_addr == A_STAT);
  wire wr_evt  = wr_en && (wr_addr == A_EVT);
  wire wr_psc  = wr_en && (wr_addr == A_PSC);
  wire wr_arr  = wr_en && (wr_addr == A_ARR);

  wire sw_upd   = wr_evt && wr_data[0];
  wire tick     = run && (pcnt == psc_act);
  wire arr_zero = (arr_act == '0);
  wire hw_upd   = tick && !arr_zero && (cnt >= arr_act);
  wire upd      = sw_upd || hw_upd;

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; single <= 1'b0; buffered <= 1'b0;
    end else if (wr_ctrl) begin
      run <= wr_data[0]; single <= wr_data[1]; buffered <= wr_data[2];
    end else if (hw_upd && single) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien <= 1'b0;
    else if (wr_ien) ien <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (upd) flag <= 1'b1;
    else if (wr_stat && !wr_data[0]) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre <= '0; psc_act <= '0;
    end else begin
      if (wr_psc) psc_pre <= wr_data[PSC_W-1:0];
      if (upd) psc_act <= psc_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_pre <= '0; arr_act <= '0;
    end else begin
      if (wr_arr) arr_pre <= wr_data[CNT_W-1:0];
      if (wr_arr && !buffered) arr_act <= wr_data[CNT_W-1:0];
      else if (upd) arr_act <= arr_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; cnt <= '0;
    end else if (upd) begin
      pcnt <= '0; cnt <= '0;
    end else if (run) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) cnt <= arr_zero ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {29'd0, buffered, single, run};
      A_IEN:   rd_data = {31'd0, ien};
      A_STAT:  rd_data = {31'd0, flag};
      A_PSC:   rd_data = 32'(psc_pre);
      A_ARR:   rd_data = 32'(arr_pre);
      A_CNT:   rd_data = 32'(cnt);
      default: rd_data = 32'd0;
    endcase
  end

  assign irq = flag & ien;

  p_update_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flag);
  p_single_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_upd && single && !wr_ctrl) |=> !run);
  p_psc_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(psc_act));
  p_zero_reload_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_zero && !sw_upd) |=> !$rose(flag));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !upd) |=> $stable(cnt));
endmodule

// File: tb/upd_timer_tb.sv
`timescale 1ns/1ps
module upd_timer_tb_top;
  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h04, A_STAT = 8'h08,
                         A_EVT = 8'h0C, A_PSC = 8'h10, A_ARR = 8'h14, A_CNT = 8'h18;
  localparam int NV = 5;
  localparam int VPSC [NV] = '{0, 1, 3, 0, 2};
  localparam int VARR [NV] = '{1, 5, 2, 9, 4};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  upd_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic measure(output int n);
    bit got = 1'b0;
    n = 0; rd_addr = A_STAT;
    while (n < 500 && !got) begin
      @(posedge clk); #1; n++; got = rd_data[0];
    end
  endtask

  task automatic arm(input int psc, input int arr, input logic [31:0] ctrl);
    wr(A_CTRL, 32'(ctrl & 32'h4)); wr(A_PSC, 32'(psc)); wr(A_ARR, 32'(arr));
    wr(A_EVT, 32'd1); wr(A_STAT, 32'd0); wr(A_CTRL, ctrl);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1, c2;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    for (int a = 0; a <= 24; a += 4) begin
      rd(8'(a), v); chk("R1 reset register", v, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      arm(VPSC[i], VARR[i], 32'd1);
      measure(n);
      chk("R2 update period", 32'(n), 32'((VARR[i] + 1) * (VPSC[i] + 1)));
      rd(A_CNT, v); chk("R2 restart at zero", v, 32'd0);
      wr(A_CTRL, 32'd0);
    end

    wr(A_ARR, 32'hFFFF_FFFF); rd(A_ARR, v); chk("R10 width readback", v, 32'h0000_FFFF);

    wr(A_STAT, 32'd0); rd(A_CNT, c1); wr(A_EVT, 32'd0);
    rd(A_STAT, v); chk("R8 zero event write flag", v, 32'd0);
    rd(A_CNT, v); chk("R8 zero event write count", v, c1);

    arm(0, 0, 32'd1);
    repeat (20) @(posedge clk); #1;
    rd(A_STAT, v); chk("R9 no update at zero reload", v, 32'd0);
    rd(A_CNT, v); chk("R9 counter parked", v, 32'd0);

    wr(A_EVT, 32'd1); rd(A_STAT, v); chk("R8 forced update sets flag", v, 32'd1);
    wr(A_STAT, 32'd1); rd(A_STAT, v); chk("R4 write one keeps flag", v, 32'd1);
    wr(A_IEN, 32'd1); #1; chk("R3 irq when enabled", {31'd0, irq}, 32'd1);
    wr(A_IEN, 32'd0); #1; chk("R3 irq masked", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'd1); wr(A_STAT, 32'd0);
    rd(A_STAT, v); chk("R4 write zero clears", v, 32'd0);
    chk("R3 irq drops with flag", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'd0);

    arm(0, 200, 32'd1);
    wr(A_PSC, 32'd3);
    rd(A_CNT, c1); @(posedge clk); #1; rd(A_CNT, c2);
    chk("R6 divider not yet active", c2, c1 + 32'd1);
    wr(A_EVT, 32'd1);
    repeat (3) @(posedge clk); #1; rd(A_CNT, v);
    chk("R6 divider active after update", v, 32'd0);
    @(posedge clk); #1; rd(A_CNT, v);
    chk("R8 forced update restarts phase", v, 32'd1);

    arm(0, 200, 32'd5);
    wr(A_ARR, 32'd3); rd(A_ARR, v); chk("R7 pending reload readback", v, 32'd3);
    repeat (10) @(posedge clk); #1;
    rd(A_CNT, v); chk("R7 old reload still active", {31'd0, v > 32'd3}, 32'd1);
    rd(A_STAT, v); chk("R7 no early update", v, 32'd0);
    wr(A_CTRL, 32'd4); wr(A_EVT, 32'd1); wr(A_STAT, 32'd0); wr(A_CTRL, 32'd5);
    measure(n); chk("R7 buffered reload after update", 32'(n), 32'd4);
    wr(A_CTRL, 32'd0);

    arm(0, 2, 32'd3);
    measure(n); chk("R5 single-shot delay", 32'(n), 32'd3);
    rd(A_CTRL, v); chk("R5 run cleared", v, 32'd2);
    wr(A_STAT, 32'd0);
    repeat (10) @(posedge clk); #1;
    rd(A_STAT, v); chk("R5 no second update", v, 32'd0);
    rd(A_CNT, v); chk("R5 counter stays zero", v, 32'd0);

    wr(A_ARR, 32'd200); wr(A_CTRL, 32'd1);
    repeat (5) @(posedge clk);
    wr(A_CTRL, 32'd0); rd(A_CNT, c1);
    repeat (5) @(posedge clk); #1; rd(A_CNT, c2);
    chk("R11 stopped counter holds", c2, c1);
    chk("R11 stopped counter nonzero", {31'd0, c1 != 0}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule